// File: doc/BRIEF.md
# Nonvolatile SRAM Store/Recall Sequencer

This block fronts a static memory that has a nonvolatile shadow copy. Ordinary read and write cycles go to the SRAM. A fixed run of five read addresses, followed by a sixth key read, asks for a whole-array transfer. Key `0x0FC0` saves the SRAM into the shadow copy. Key `0x0C63` restores the SRAM from the shadow copy. Reads that form the run behave like any other reads and return SRAM data.

A transfer makes the block busy for a cycle count fixed by a parameter. While the block is busy, every access is dropped and reads return zero. A restore runs in two steps. The SRAM is wiped first and then loaded from the shadow copy. The shadow copy itself is never written by a restore. A low-voltage flag stops both saves and SRAM writes, which protects the stored data while the supply is unsafe.

The interface is synchronous to `clk`. A cycle with `mem_sel` high is one access: a write when `wr_en` is high, otherwise a read. Read data appears on `rdata` in the cycle after the access. It is zero unless `rd_oe` was high during the access.

Top module: `nvs_top`

## Requirements
- R1: After reset, `busy`, `store_pulse`, `recall_pulse` and `rdata` are 0, and the unlock run stands at its first step.
- R2: A write stores `wdata` at location `addr[MEM_AW-1:0]`. After a read with `rd_oe` high, `rdata` in the next cycle holds that location's data. After a read with `rd_oe` low, `rdata` is 0.
- R3: The unlock run is reads of 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F, in that order, compared on all 15 address bits. A sixth read of 0x0FC0 starts a save. A sixth read of 0x0C63 starts a restore.
- R4: Only reads advance the run, and `rd_oe` does not need to be high for a step to count. A write at any point returns the run to step one. A read of a wrong address also returns it to step one, except that a wrong address equal to 0x0E38 restarts the run at step two.
- R5: A save copies every SRAM location into the shadow array. From the cycle after the key read, `busy` is high for exactly STORE_CYC cycles, and `store_pulse` is high for the first of those cycles only.
- R6: A restore first clears the SRAM and then loads it from the shadow array. `busy` is high for exactly RECALL_CYC cycles and `recall_pulse` for the first of them. The shadow array is left unchanged, so restores can be repeated without limit.
- R7: While `low_volt` is 1, a completed run with the save key starts nothing (`busy` stays 0), and writes leave the SRAM unchanged.
- R8: While `busy` is 1, accesses have no effect on the memory or on the run, and a read returns `rdata` = 0.
- R9: Reads that are part of the unlock run return normal SRAM data.
- R10: A sixth read of any address other than the two keys starts no operation, and the run returns to step one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_sel | input | 1 | Access this cycle |
| wr_en | input | 1 | 1 = write access, 0 = read access |
| rd_oe | input | 1 | Read data is driven only when this is high |
| low_volt | input | 1 | Supply below safe level |
| addr | input | 15 | Byte address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, one cycle after the access |
| busy | output | 1 | Save or restore in progress |
| store_pulse | output | 1 | First cycle of a save |
| recall_pulse | output | 1 | First cycle of a restore |

## Verification
The whole small array is swept with three data patterns, each computed from the location index. Because the patterns differ, the bench can tell which data each location holds: restored data, written data, or leftover data. The unlock run is tried in several forms: exact, with `rd_oe` low, with a stray read, with a write in the middle, with a repeated first address, and with a wrong sixth key. Each form shows whether `busy` rises, which separates the step-restart rules from one another. Accesses are issued on every cycle of each busy period, and the busy cycles are counted, so that the exact duration, the ignoring of accesses and the low-voltage lockout can each be seen at the ports.

// File: rtl/nvs_pkg.sv
// Shared constants and types for the store/recall sequencer.
// Assumes a 15-bit byte address; the unlock keys are full-width compares.
package nvs_pkg;
    localparam int ADDR_W = 15;
    localparam int RUN_LEN = 5;
    localparam logic [ADDR_W-1:0] UNLOCK_RUN [RUN_LEN] =
        '{15'h0E38, 15'h31C7, 15'h03E0, 15'h3C1F, 15'h303F};
    localparam logic [ADDR_W-1:0] SAVE_KEY    = 15'h0FC0;
    localparam logic [ADDR_W-1:0] RESTORE_KEY = 15'h0C63;

    typedef enum logic [1:0] {
        OP_NONE    = 2'd0,
        OP_SAVE    = 2'd1,
        OP_RESTORE = 2'd2
    } op_e;
endpackage

// File: rtl/nvs_unlock.sv
// Unlock run detector: tracks how many run addresses have been read in order
// and raises a one-cycle command when the sixth read hits a key address.
// Assumes acc_rd/acc_wr are already suppressed while an operation is busy.
module nvs_unlock
    import nvs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic              low_volt,
    output op_e               cmd
);
    localparam int STEP_W = $clog2(RUN_LEN + 1);
    localparam logic [STEP_W-1:0] LAST = STEP_W'(RUN_LEN);

    logic [STEP_W-1:0] step_q;
    logic [STEP_W-1:0] step_d;
    logic              run_hit;

    // Compare the address against the run entry expected at the current step.
    always_comb begin
        run_hit = 1'b0;
        for (int i = 0; i < RUN_LEN; i++) begin
            if (step_q == STEP_W'(i) && addr == UNLOCK_RUN[i]) run_hit = 1'b1;
        end
    end

    // Next step and command decode.
    always_comb begin
        step_d = step_q;
        cmd    = OP_NONE;
        if (acc_wr) begin
            step_d = '0;
        end else if (acc_rd) begin
            if (step_q == LAST) begin
                if (addr == SAVE_KEY && !low_volt) cmd = OP_SAVE;
                else if (addr == RESTORE_KEY)      cmd = OP_RESTORE;
                step_d = (addr == UNLOCK_RUN[0]) ? STEP_W'(1) : '0;
            end else if (run_hit) begin
                step_d = step_q + STEP_W'(1);
            end else if (addr == UNLOCK_RUN[0]) begin
                step_d = STEP_W'(1);
            end else begin
                step_d = '0;
            end
        end
    end

    // Step register.
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= '0;
        else        step_q <= step_d;
    end

    assert_step_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        step_q <= LAST);
    assert_write_resets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr |=> step_q == '0);
    assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_rd || acc_wr) |=> $stable(step_q));
endmodule

// File: rtl/nvs_timer.sv
// Operation timer: loads the save or restore duration on a command, keeps
// busy high for exactly that many cycles and emits a first-cycle strobe.
// Assumes RESTORE_CYC >= 2 so both restore phases fit inside busy.
module nvs_timer
    import nvs_pkg::*;
#(
    parameter int STORE_CYC   = 64,
    parameter int RESTORE_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  op_e  cmd,
    output logic busy,
    output logic save_stb,
    output logic restore_stb
);
    localparam int MAX_CYC = (STORE_CYC > RESTORE_CYC) ? STORE_CYC : RESTORE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt_q;

    assign busy = (cnt_q != '0);

    // Countdown and strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            save_stb    <= 1'b0;
            restore_stb <= 1'b0;
        end else begin
            save_stb    <= 1'b0;
            restore_stb <= 1'b0;
            if (!busy && cmd == OP_SAVE) begin
                cnt_q    <= CNT_W'(STORE_CYC);
                save_stb <= 1'b1;
            end else if (!busy && cmd == OP_RESTORE) begin
                cnt_q       <= CNT_W'(RESTORE_CYC);
                restore_stb <= 1'b1;
            end else if (busy) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    assert_busy_countdown_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> cnt_q == $past(cnt_q) - CNT_W'(1));
    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({save_stb, restore_stb}));
    assert_strobe_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (save_stb || restore_stb) |-> busy);
endmodule

// File: rtl/nvs_arrays.sv
// Storage model: an SRAM array and a shadow nonvolatile array of equal size.
// A save copies the SRAM into the shadow; a restore clears the SRAM and then
// loads it from the shadow. Read data is registered and zero when not read.
module nvs_arrays #(
    parameter int MEM_AW = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [MEM_AW-1:0] loc,
    input  logic [DATA_W-1:0] wdata,
    input  logic              do_save,
    input  logic              do_clear,
    input  logic              do_load,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << MEM_AW;

    logic [DATA_W-1:0] sram_q [DEPTH];
    logic [DATA_W-1:0] shadow_q [DEPTH];

    // SRAM update: load beats clear beats write.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (do_load)                                 sram_q[i] <= shadow_q[i];
            else if (do_clear)                           sram_q[i] <= '0;
            else if (wr_en && loc == MEM_AW'(i))         sram_q[i] <= wdata;
        end
    end

    // Shadow update: written only by a save.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (do_save) shadow_q[i] <= sram_q[i];
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= sram_q[loc];
        else            rdata <= '0;
    end

    assert_clear_before_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        do_load |-> $past(do_clear));
    assert_save_not_with_restore_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(do_save && (do_clear || do_load)));
endmodule

// File: rtl/nvs_top.sv
// Store/recall sequencer top: gates accesses with busy and the low-voltage
// flag, feeds reads to the unlock detector, and drives the arrays and timer.
// Assumes one access per cycle, qualified by mem_sel.
module nvs_top
    import nvs_pkg::*;
#(
    parameter int MEM_AW      = 8,
    parameter int DATA_W      = 8,
    parameter int STORE_CYC   = 64,
    parameter int RESTORE_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_sel,
    input  logic              wr_en,
    input  logic              rd_oe,
    input  logic              low_volt,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              busy,
    output logic              store_pulse,
    output logic              recall_pulse
);
    logic acc_ok;
    logic acc_rd;
    logic acc_wr;
    op_e  cmd;

    // Access qualification: nothing gets through while an operation runs.
    always_comb begin
        acc_ok = mem_sel && !busy;
        acc_rd = acc_ok && !wr_en;
        acc_wr = acc_ok && wr_en;
    end

    nvs_unlock u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_rd   (acc_rd),
        .acc_wr   (acc_wr),
        .addr     (addr),
        .low_volt (low_volt),
        .cmd      (cmd)
    );

    nvs_timer #(
        .STORE_CYC   (STORE_CYC),
        .RESTORE_CYC (RESTORE_CYC)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd         (cmd),
        .busy        (busy),
        .save_stb    (store_pulse),
        .restore_stb (recall_pulse)
    );

    nvs_arrays #(
        .MEM_AW (MEM_AW),
        .DATA_W (DATA_W)
    ) u_arrays (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (acc_wr && !low_volt),
        .rd_en    (acc_rd && rd_oe),
        .loc      (addr[MEM_AW-1:0]),
        .wdata    (wdata),
        .do_save  (cmd == OP_SAVE),
        .do_clear (cmd == OP_RESTORE),
        .do_load  (recall_pulse),
        .rdata    (rdata)
    );

    assert_busy_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> rdata == '0);
    assert_no_save_low_volt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        store_pulse |-> $past(!low_volt));
    assert_busy_starts_with_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (store_pulse || recall_pulse));
endmodule

// File: tb/tb_nvs_top.sv
module tb_nvs_top;
    localparam int MEM_AW = 4;
    localparam int DATA_W = 8;
    localparam int SC = 5;
    localparam int RC = 7;
    localparam int DEPTH = 1 << MEM_AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mem_sel = 1'b0, wr_en = 1'b0, rd_oe = 1'b0, low_volt = 1'b0;
    logic [14:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic busy, store_pulse, recall_pulse;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [DATA_W-1:0] model [DEPTH];

    always #5 clk = ~clk;

    nvs_top #(.MEM_AW(MEM_AW), .DATA_W(DATA_W), .STORE_CYC(SC), .RESTORE_CYC(RC)) dut (
        .clk(clk), .rst_n(rst_n), .mem_sel(mem_sel), .wr_en(wr_en), .rd_oe(rd_oe),
        .low_volt(low_volt), .addr(addr), .wdata(wdata), .rdata(rdata),
        .busy(busy), .store_pulse(store_pulse), .recall_pulse(recall_pulse));

    function automatic logic [DATA_W-1:0] pat(int k, int i);
        return DATA_W'((i * 37 + k * 91 + 5) & 8'hFF);
    endfunction

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(bit w, logic [14:0] a, logic [DATA_W-1:0] d, bit oe);
        @(negedge clk);
        mem_sel = 1'b1; wr_en = w; addr = a; wdata = d; rd_oe = oe;
        @(posedge clk); #1;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            mem_sel = 1'b0; wr_en = 1'b0; rd_oe = 1'b0;
            @(posedge clk); #1;
        end
    endtask

    task automatic fill(int k);
        for (int i = 0; i < DEPTH; i++) begin
            access(1'b1, 15'(i), pat(k, i), 1'b0);
            if (!low_volt) model[i] = pat(k, i);
        end
    endtask

    task automatic verify_all(string req);
        for (int i = 0; i < DEPTH; i++) begin
            access(1'b0, 15'(i), '0, 1'b1);
            check(req, int'(rdata), int'(model[i]));
        end
    endtask

    // Five run reads; R9 checks their data when oe is high.
    task automatic run_prefix(bit oe);
        logic [14:0] runs [5] = '{15'h0E38, 15'h31C7, 15'h03E0, 15'h3C1F, 15'h303F};
        for (int s = 0; s < 5; s++) begin
            access(1'b0, runs[s], '0, oe);
            if (oe) check("R9 run read data", int'(rdata), int'(model[runs[s][MEM_AW-1:0]]));
        end
    endtask

    // Count busy cycles while hammering accesses (R8).
    task automatic ride_busy(string req, int exp_len, bit is_save);
        int n = 1;
        int guard = 0;
        bit pre;
        bit w = 1'b1;
        check({req, " busy rise"}, int'(busy), 1);
        check({req, " strobe"}, is_save ? int'(store_pulse) : int'(recall_pulse), 1);
        while (busy && guard < 100) begin
            pre = busy;
            access(w, 15'h0000, 8'hA5, 1'b1);
            if (guard == 0) check({req, " strobe single"}, int'(store_pulse | recall_pulse), 0);
            if (!w && pre) check("R8 busy read zero", int'(rdata), 0);
            if (busy) n++;
            w = !w;
            guard++;
        end
        check({req, " busy length"}, n, exp_len);
        idle(1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 busy", int'(busy), 0);
        check("R1 store_pulse", int'(store_pulse), 0);
        check("R1 recall_pulse", int'(recall_pulse), 0);
        check("R1 rdata", int'(rdata), 0);
        @(negedge clk); rst_n = 1'b1;
        idle(1);

        // R2: write/read sweep and oe gating
        fill(0);
        verify_all("R2 read back");
        access(1'b0, 15'h0003, '0, 1'b0);
        check("R2 oe low gives zero", int'(rdata), 0);

        // R3/R5: save, with accesses during busy ignored (R8)
        run_prefix(1'b1);
        access(1'b0, 15'h0FC0, '0, 1'b1);
        check("R9 key read data", int'(rdata), int'(model[0]));
        ride_busy("R5 save", SC, 1'b1);
        verify_all("R8 memory untouched by busy writes");

        // R6: restore, twice
        fill(1);
        run_prefix(1'b1);
        access(1'b0, 15'h0C63, '0, 1'b1);
        ride_busy("R6 restore", RC, 1'b0);
        for (int i = 0; i < DEPTH; i++) model[i] = pat(0, i);
        verify_all("R6 restored data");
        fill(2);
        run_prefix(1'b0);
        access(1'b0, 15'h0C63, '0, 1'b0);
        ride_busy("R6 second restore", RC, 1'b0);
        for (int i = 0; i < DEPTH; i++) model[i] = pat(0, i);
        verify_all("R6 shadow unchanged");

        // R7: low voltage blocks writes and saves
        low_volt = 1'b1;
        fill(3);
        verify_all("R7 write ignored");
        run_prefix(1'b1);
        access(1'b0, 15'h0FC0, '0, 1'b1);
        check("R7 no save under low voltage", int'(busy), 0);
        idle(2);
        check("R7 still idle", int'(busy), 0);
        low_volt = 1'b0;
        fill(1);
        run_prefix(1'b1);
        access(1'b0, 15'h0C63, '0, 1'b1);
        ride_busy("R7 restore", RC, 1'b0);
        for (int i = 0; i < DEPTH; i++) model[i] = pat(0, i);
        verify_all("R7 shadow kept old data");

        // R4: stray read breaks the run
        access(1'b0, 15'h0E38, '0, 1'b1);
        access(1'b0, 15'h31C7, '0, 1'b1);
        access(1'b0, 15'h0005, '0, 1'b1);
        access(1'b0, 15'h03E0, '0, 1'b1);
        access(1'b0, 15'h3C1F, '0, 1'b1);
        access(1'b0, 15'h303F, '0, 1'b1);
        access(1'b0, 15'h0C63, '0, 1'b1);
        check("R4 stray read resets", int'(busy), 0);
        // R4: write in the middle breaks the run
        access(1'b0, 15'h0E38, '0, 1'b1);
        access(1'b0, 15'h31C7, '0, 1'b1);
        access(1'b1, 15'h03E0, model[0], 1'b0);
        access(1'b0, 15'h03E0, '0, 1'b1);
        access(1'b0, 15'h3C1F, '0, 1'b1);
        access(1'b0, 15'h303F, '0, 1'b1);
        access(1'b0, 15'h0C63, '0, 1'b1);
        check("R4 write resets", int'(busy), 0);
        // R4: repeated first address restarts at step two
        access(1'b0, 15'h0E38, '0, 1'b1);
        access(1'b0, 15'h31C7, '0, 1'b1);
        run_prefix(1'b1);
        access(1'b0, 15'h0C63, '0, 1'b1);
        ride_busy("R4 restart at step two", RC, 1'b0);
        // R4: oe low still counts
        run_prefix(1'b0);
        access(1'b0, 15'h0C63, '0, 1'b0);
        ride_busy("R4 oe low run", RC, 1'b0);

        // R10: wrong key, then a good run right after
        run_prefix(1'b1);
        access(1'b0, 15'h0C64, '0, 1'b1);
        check("R10 wrong key idle", int'(busy), 0);
        access(1'b0, 15'h3C1F, '0, 1'b1);
        access(1'b0, 15'h303F, '0, 1'b1);
        check("R10 run reset", int'(busy), 0);
        run_prefix(1'b1);
        access(1'b0, 15'h0FC0, '0, 1'b1);
        ride_busy("R3 save after wrong key", SC, 1'b1);
        verify_all("R3 data after save");

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule